// File: doc/BRIEF.md
# Dual-Port Shared RAM with Contention Flags and Mailbox Interrupts

This block is a synchronous shared memory of 2048 bytes with two symmetric ports, called left and right. Each port has its own enable, write strobe, output gate, address and data buses, so two agents can read and write any location on the same clock. Read data is registered and appears one cycle after the request. The output gate only forces the read bus to zero. It does not touch the stored contents.

When both ports address the same word and at least one of them writes, the block raises a busy flag on one port only. The port that has held that address longer keeps going, and the port that arrived later is told to wait. A busy port's write is discarded, and its read register keeps its old value until the flag drops. Two simultaneous reads of one word never conflict.

A parameter selects the role of an instance. A primary instance arbitrates and drives the busy flags. A follower instance takes its busy flags from its inputs, so several instances can be ganged on the same address and control buses to build wider words. The two highest addresses serve as mailboxes. A left write to the top address raises the right interrupt, and a right read of it lowers that interrupt. A right write to the address just below raises the left interrupt, and a left read of it lowers it.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: A port with enable high and write strobe low loads the addressed word into its read register on the clock edge, so the value appears on its read bus in the next cycle. With enable and write strobe both high, the word is stored on the edge.
- R2: Both ports can access different addresses in the same cycle, and each access takes effect without any busy flag.
- R3: While a port's enable is low, that port neither writes nor updates its read register, whatever its write strobe and address are.
- R4: While a port's output gate is low its read bus is 0. When the gate is high the bus shows the read register, and the gate never changes stored data.
- R5: Both ports reading the same address in the same cycle raise no busy flag, and both receive the stored word.
- R6: A conflict exists when both enables are high, the addresses are equal and at least one port writes. During a conflict exactly one busy flag is high, and it goes to the port whose address was not already present, with its enable high, in the previous cycle. If both ports arrive in the same cycle, the right port gets the busy flag. The flag is valid in the same cycle as the request.
- R7: The write of a busy port is dropped and is not retried. The read register of a busy port holds its previous value.
- R8: A follower instance (primary parameter 0) takes its busy flags from its busy inputs and repeats them on its busy outputs. A busy input blocks that port's write and holds its read register just as an internal busy flag would.
- R9: An accepted left write to address 0x7FF sets the right interrupt at the next edge. An accepted right read of 0x7FF clears it, and a left read of 0x7FF leaves it unchanged.
- R10: An accepted right write to address 0x7FE sets the left interrupt at the next edge. An accepted left read of 0x7FE clears it.
- R11: After synchronous reset both read registers are 0, and both interrupts and both busy flags are low.
- R12: While a conflict continues with neither address changing and both enables held high, the busy flag stays on the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_ce | input | 1 | Left port enable |
| left_we | input | 1 | Left write strobe |
| left_oe | input | 1 | Left read bus gate |
| left_addr | input | AW | Left word address |
| left_wdata | input | DW | Left write data |
| left_rdata | output | DW | Left read data |
| left_busy_o | output | 1 | Left busy flag |
| left_busy_i | input | 1 | Left busy input, used by a follower |
| left_irq | output | 1 | Left mailbox interrupt |
| right_ce | input | 1 | Right port enable |
| right_we | input | 1 | Right write strobe |
| right_oe | input | 1 | Right read bus gate |
| right_addr | input | AW | Right word address |
| right_wdata | input | DW | Right write data |
| right_rdata | output | DW | Right read data |
| right_busy_o | output | 1 | Right busy flag |
| right_busy_i | input | 1 | Right busy input, used by a follower |
| right_irq | output | 1 | Right mailbox interrupt |

## Verification
Arbitration is exercised with three arrival orders on one address. In the first the left port was already there, in the second the right port was, and in the third both arrive in the same cycle. Together these separate "the older address wins" from a fixed-priority arbiter and from the tie rule. Another pattern holds a conflict for two cycles to show the winner is kept rather than recomputed. Paired reads of one word, paired accesses to different words, disabled and ungated accesses, and mailbox sequences check that contention logic does not leak into the cases where no flag may rise. A follower instance ganged to the primary sees every pattern, which shows that its blocking follows the busy inputs alone.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
  localparam int NPORTS = 2;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } winner_e;
endpackage

// File: rtl/dpr_mem.sv
module dpr_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      wr_en,
  input  logic [1:0]      rd_en,
  input  logic [2*AW-1:0] addr,
  input  logic [2*DW-1:0] wdata,
  output logic [2*DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // both write ports share one process so the array has a single driver
  always_ff @(posedge clk) begin
    if (wr_en[0]) store[addr[0 +: AW]] <= wdata[0 +: DW];
    if (wr_en[1]) store[addr[AW +: AW]] <= wdata[DW +: DW];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (rd_en[p])  q <= store[addr[p*AW +: AW]];
    end
    assign rdata[p*DW +: DW] = q;
  end

  // R6: the arbiter must never let both ports write one word together
  a_r6_no_double_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_en[0] && wr_en[1] && (addr[0 +: AW] == addr[AW +: AW])));
endmodule

// File: rtl/dpr_arb.sv
module dpr_arb
  import dpr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_l,
  input  logic          we_l,
  input  logic [AW-1:0] addr_l,
  input  logic          ce_r,
  input  logic          we_r,
  input  logic [AW-1:0] addr_r,
  output logic          busy_l,
  output logic          busy_r
);
  logic [AW-1:0] prev_addr_l, prev_addr_r;
  logic          prev_ce_l, prev_ce_r;
  logic          clash_q;
  winner_e       win_q, win_d;
  logic          clash, fresh_l, fresh_r;

  assign clash   = ce_l && ce_r && (addr_l == addr_r) && (we_l || we_r);
  assign fresh_l = !(prev_ce_l && (prev_addr_l == addr_l));
  assign fresh_r = !(prev_ce_r && (prev_addr_r == addr_r));

  always_comb begin
    if (fresh_l && !fresh_r)       win_d = WIN_RIGHT;
    else if (!fresh_l && fresh_r)  win_d = WIN_LEFT;
    else if (!fresh_l && clash_q)  win_d = win_q;
    else                           win_d = WIN_LEFT;
  end

  assign busy_l = clash && (win_d == WIN_RIGHT);
  assign busy_r = clash && (win_d == WIN_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ce_l   <= 1'b0;
      prev_ce_r   <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      clash_q     <= 1'b0;
      win_q       <= WIN_LEFT;
    end else begin
      prev_ce_l   <= ce_l;
      prev_ce_r   <= ce_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      clash_q     <= clash;
      win_q       <= win_d;
    end
  end

  // R6: at most one loser
  a_r6_one_loser: assert property (@(posedge clk) disable iff (rst)
    !(busy_l && busy_r));

  // R5: two reads never contend
  a_r5_reads_free: assert property (@(posedge clk) disable iff (rst)
    (ce_l && ce_r && !we_l && !we_r) |-> (!busy_l && !busy_r));

  // R12: a held conflict keeps its loser
  a_r12_keep_left_loser: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_l) && ce_l && ce_r && $past(ce_l) && $past(ce_r) &&
     $stable(addr_l) && $stable(addr_r) && (we_l || we_r)) |-> busy_l);

  a_r12_keep_right_loser: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_r) && ce_l && ce_r && $past(ce_l) && $past(ce_r) &&
     $stable(addr_l) && $stable(addr_r) && (we_l || we_r)) |-> busy_r);
endmodule

// File: rtl/dpr_mbox.sv
module dpr_mbox #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  output logic          l_flag,
  output logic          r_flag
);
  localparam logic [AW-1:0] TO_RIGHT = {AW{1'b1}};
  localparam logic [AW-1:0] TO_LEFT  = {{(AW-1){1'b1}}, 1'b0};

  logic post_r, take_r, post_l, take_l;

  assign post_r = l_wr && (l_addr == TO_RIGHT);
  assign take_r = r_rd && (r_addr == TO_RIGHT);
  assign post_l = r_wr && (r_addr == TO_LEFT);
  assign take_l = l_rd && (l_addr == TO_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_flag <= 1'b0;
      l_flag <= 1'b0;
    end else begin
      if (post_r)      r_flag <= 1'b1;
      else if (take_r) r_flag <= 1'b0;
      if (post_l)      l_flag <= 1'b1;
      else if (take_l) l_flag <= 1'b0;
    end
  end

  // R9
  a_r9_set_right: assert property (@(posedge clk) disable iff (rst)
    (l_wr && (l_addr == TO_RIGHT)) |=> r_flag);
  a_r9_clear_right: assert property (@(posedge clk) disable iff (rst)
    (r_rd && (r_addr == TO_RIGHT) && !l_wr) |=> !r_flag);
  // R10
  a_r10_set_left: assert property (@(posedge clk) disable iff (rst)
    (r_wr && (r_addr == TO_LEFT)) |=> l_flag);
  a_r10_clear_left: assert property (@(posedge clk) disable iff (rst)
    (l_rd && (l_addr == TO_LEFT) && !r_wr) |=> !l_flag);
endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram
  import dpr_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          left_ce,
  input  logic          left_we,
  input  logic          left_oe,
  input  logic [AW-1:0] left_addr,
  input  logic [DW-1:0] left_wdata,
  output logic [DW-1:0] left_rdata,
  output logic          left_busy_o,
  input  logic          left_busy_i,
  output logic          left_irq,
  input  logic          right_ce,
  input  logic          right_we,
  input  logic          right_oe,
  input  logic [AW-1:0] right_addr,
  input  logic [DW-1:0] right_wdata,
  output logic [DW-1:0] right_rdata,
  output logic          right_busy_o,
  input  logic          right_busy_i,
  output logic          right_irq
);
  logic                  busy_l, busy_r;
  logic [NPORTS-1:0]     wr_acc, rd_acc;
  logic [NPORTS*DW-1:0]  q_bus;
  logic [DW-1:0]         q_l, q_r;

  if (IS_MASTER) begin : g_master
    logic unused_busy_in;
    assign unused_busy_in = left_busy_i ^ right_busy_i;
    dpr_arb #(.AW(AW)) u_arb (
      .clk   (clk),
      .rst   (rst),
      .ce_l  (left_ce),
      .we_l  (left_we),
      .addr_l(left_addr),
      .ce_r  (right_ce),
      .we_r  (right_we),
      .addr_r(right_addr),
      .busy_l(busy_l),
      .busy_r(busy_r)
    );
  end else begin : g_slave
    assign busy_l = left_busy_i;
    assign busy_r = right_busy_i;
  end

  assign left_busy_o  = busy_l;
  assign right_busy_o = busy_r;

  assign wr_acc[PORT_L] = left_ce  &&  left_we  && !busy_l;
  assign rd_acc[PORT_L] = left_ce  && !left_we  && !busy_l;
  assign wr_acc[PORT_R] = right_ce &&  right_we && !busy_r;
  assign rd_acc[PORT_R] = right_ce && !right_we && !busy_r;

  dpr_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_acc),
    .rd_en(rd_acc),
    .addr ({right_addr, left_addr}),
    .wdata({right_wdata, left_wdata}),
    .rdata(q_bus)
  );

  assign q_l = q_bus[PORT_L*DW +: DW];
  assign q_r = q_bus[PORT_R*DW +: DW];

  assign left_rdata  = left_oe  ? q_l : '0;
  assign right_rdata = right_oe ? q_r : '0;

  dpr_mbox #(.AW(AW)) u_mbox (
    .clk   (clk),
    .rst   (rst),
    .l_wr  (wr_acc[PORT_L]),
    .l_rd  (rd_acc[PORT_L]),
    .l_addr(left_addr),
    .r_wr  (wr_acc[PORT_R]),
    .r_rd  (rd_acc[PORT_R]),
    .r_addr(right_addr),
    .l_flag(left_irq),
    .r_flag(right_irq)
  );

  // R7: a busy port keeps its read register
  a_r7_hold_left: assert property (@(posedge clk) disable iff (rst)
    busy_l |=> $stable(q_l));
  a_r7_hold_right: assert property (@(posedge clk) disable iff (rst)
    busy_r |=> $stable(q_r));
  // R3: a disabled port keeps its read register
  a_r3_idle_left: assert property (@(posedge clk) disable iff (rst)
    !left_ce |=> $stable(q_l));
  a_r3_idle_right: assert property (@(posedge clk) disable iff (rst)
    !right_ce |=> $stable(q_r));
endmodule

// File: tb/dual_port_mailbox_ram_tb.sv
module dual_port_mailbox_ram_tb;
  localparam int AW = 11;
  localparam int DW = 8;

  typedef struct packed {
    logic          ce;
    logic          we;
    logic          oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } cmd_t;

  typedef struct {
    logic [DW-1:0] el, er, esl, esr;
    logic          bl, br, il, ir;
    string         req;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  cmd_t lc, rc;
  logic [DW-1:0] m_lrd, m_rrd, s_lrd, s_rrd;
  logic m_lbusy, m_rbusy, s_lbusy, s_rbusy;
  logic m_lirq, m_rirq, s_lirq, s_rirq;

  dual_port_mailbox_ram #(.AW(AW), .DW(DW), .IS_MASTER(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .left_ce(lc.ce), .left_we(lc.we), .left_oe(lc.oe), .left_addr(lc.a),
    .left_wdata(lc.d), .left_rdata(m_lrd), .left_busy_o(m_lbusy),
    .left_busy_i(1'b0), .left_irq(m_lirq),
    .right_ce(rc.ce), .right_we(rc.we), .right_oe(rc.oe), .right_addr(rc.a),
    .right_wdata(rc.d), .right_rdata(m_rrd), .right_busy_o(m_rbusy),
    .right_busy_i(1'b0), .right_irq(m_rirq)
  );

  dual_port_mailbox_ram #(.AW(AW), .DW(DW), .IS_MASTER(1'b0)) u_slv (
    .clk(clk), .rst(rst),
    .left_ce(lc.ce), .left_we(lc.we), .left_oe(lc.oe), .left_addr(lc.a),
    .left_wdata(lc.d ^ 8'hA5), .left_rdata(s_lrd), .left_busy_o(s_lbusy),
    .left_busy_i(m_lbusy), .left_irq(s_lirq),
    .right_ce(rc.ce), .right_we(rc.we), .right_oe(rc.oe), .right_addr(rc.a),
    .right_wdata(rc.d ^ 8'hA5), .right_rdata(s_rrd), .right_busy_o(s_rbusy),
    .right_busy_i(m_rbusy), .right_irq(s_rirq)
  );

  int checks = 0;
  int fails  = 0;
  rec_t sb[$];

  logic [DW-1:0] mm [1 << AW];
  logic [DW-1:0] ms [1 << AW];
  logic [DW-1:0] hq_l = '0, hq_r = '0, hs_l = '0, hs_r = '0;
  logic mil = 1'b0, mir = 1'b0;

  function automatic cmd_t idle();
    return '{ce: 1'b0, we: 1'b0, oe: 1'b1, a: '0, d: '0};
  endfunction
  function automatic cmd_t rd(input logic [AW-1:0] a);
    return '{ce: 1'b1, we: 1'b0, oe: 1'b1, a: a, d: '0};
  endfunction
  function automatic cmd_t wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return '{ce: 1'b1, we: 1'b1, oe: 1'b1, a: a, d: d};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input cmd_t l, input cmd_t r, input logic bl, input logic br,
                      input string req);
    rec_t e;
    logic lwr, lrd, rwr, rrd;
    @(negedge clk); #1;
    lc = l; rc = r;
    lwr = l.ce && l.we && !bl;  lrd = l.ce && !l.we && !bl;
    rwr = r.ce && r.we && !br;  rrd = r.ce && !r.we && !br;
    if (lrd) begin hq_l = mm[l.a]; hs_l = ms[l.a]; end
    if (rrd) begin hq_r = mm[r.a]; hs_r = ms[r.a]; end
    if (lwr) begin mm[l.a] = l.d; ms[l.a] = l.d ^ 8'hA5; end
    if (rwr) begin mm[r.a] = r.d; ms[r.a] = r.d ^ 8'hA5; end
    if (lwr && l.a == 11'h7FF)      mir = 1'b1;
    else if (rrd && r.a == 11'h7FF) mir = 1'b0;
    if (rwr && r.a == 11'h7FE)      mil = 1'b1;
    else if (lrd && l.a == 11'h7FE) mil = 1'b0;
    e.el  = l.oe ? hq_l : '0;
    e.er  = r.oe ? hq_r : '0;
    e.esl = l.oe ? hs_l : '0;
    e.esr = r.oe ? hs_r : '0;
    e.bl = bl; e.br = br; e.il = mil; e.ir = mir;
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor: at each falling edge, compares the previous cycle's expectation
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      rec_t e;
      e = sb.pop_front();
      chk(e.req, "left rdata",  m_lrd, e.el);
      chk(e.req, "right rdata", m_rrd, e.er);
      chk(e.req, "left busy",   {7'd0, m_lbusy}, {7'd0, e.bl});
      chk(e.req, "right busy",  {7'd0, m_rbusy}, {7'd0, e.br});
      chk(e.req, "left irq",    {7'd0, m_lirq},  {7'd0, e.il});
      chk(e.req, "right irq",   {7'd0, m_rirq},  {7'd0, e.ir});
      // R8: the follower mirrors the primary's busy flags and blocking
      chk("R8", "follower left rdata",  s_lrd, e.esl);
      chk("R8", "follower right rdata", s_rrd, e.esr);
      chk("R8", "follower left busy",  {7'd0, s_lbusy}, {7'd0, e.bl});
      chk("R8", "follower right busy", {7'd0, s_rbusy}, {7'd0, e.br});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    lc = idle(); rc = idle();
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;

    step(idle(), idle(), 0, 0, "R11");                       // reset state
    step(wr(11'h010, 8'h55), wr(11'h100, 8'h3C), 0, 0, "R2"); // parallel writes
    step(rd(11'h100), rd(11'h010), 0, 0, "R1");               // crossed reads
    step(rd(11'h100), rd(11'h100), 0, 0, "R5");               // shared read

    // left already present, right arrives writing: right loses
    step(wr(11'h200, 8'h11), idle(), 0, 0, "R1");
    step(rd(11'h200), idle(), 0, 0, "R6");
    step(rd(11'h200), wr(11'h200, 8'hEE), 0, 1, "R6");
    step(idle(), rd(11'h200), 0, 0, "R7");                    // write was dropped

    // both arrive together: tie goes left
    step(wr(11'h300, 8'h77), rd(11'h300), 0, 1, "R6");
    step(idle(), rd(11'h300), 0, 0, "R7");

    // right already present, left arrives: left loses and keeps losing
    step(idle(), wr(11'h400, 8'h42), 0, 0, "R2");
    step(idle(), rd(11'h400), 0, 0, "R1");
    step(wr(11'h400, 8'h99), rd(11'h400), 1, 0, "R6");
    step(wr(11'h400, 8'h99), rd(11'h400), 1, 0, "R12");
    step(rd(11'h400), idle(), 0, 0, "R7");

    // disabled port ignores its strobe
    step('{ce: 1'b0, we: 1'b1, oe: 1'b1, a: 11'h010, d: 8'hFF}, idle(), 0, 0, "R3");
    step(rd(11'h010), idle(), 0, 0, "R3");

    // output gate
    step('{ce: 1'b1, we: 1'b0, oe: 1'b0, a: 11'h100, d: 8'h00}, idle(), 0, 0, "R4");
    step(idle(), idle(), 0, 0, "R4");

    // mailboxes
    step(wr(11'h7FF, 8'h5A), idle(), 0, 0, "R9");
    step(rd(11'h7FF), idle(), 0, 0, "R9");                    // own read keeps flag
    step(idle(), rd(11'h7FF), 0, 0, "R9");
    step(idle(), wr(11'h7FE, 8'hC3), 0, 0, "R10");
    step(idle(), idle(), 0, 0, "R10");
    step(rd(11'h7FE), idle(), 0, 0, "R10");

    // follower blocked by the primary's flag
    step(idle(), rd(11'h300), 0, 0, "R8");
    step(wr(11'h300, 8'h12), rd(11'h300), 1, 0, "R8");
    step(rd(11'h300), idle(), 0, 0, "R8");

    @(negedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule